// File: doc/BRIEF.md
# Duplex Link Startup Handshake Controller

This block is the state machine that sits at each end of a full-duplex serial link and takes the link from power-up to the point where user data may flow. The local frame decoder reports every received frame as a strobe, a two-bit frame kind and an error flag. From these reports the controller decides three things. It picks which fill frame the local transmitter sends. It switches the local receiver between frequency-acquisition mode and phase-tracking mode. It tells the user side whether the link is ready for data.

Lock status travels in-band. A "not locked" fill frame (fill 0) announces that an end is still training. A "locked" fill frame (fill 1) announces that its receiver has qualified lock. An end in training keeps the receiver in frequency-acquisition mode and holds ready low. It moves to phase mode only after a run of error-free fill frames. It then waits for evidence that the peer is locked before it raises ready. A frame error at either end sends that end back to training. That end then transmits fill 0, which pulls a ready peer back into training as well.

While ready is low, the transmitter that the controller steers sends only fill frames. Once ready is high, it may send data. Two instances wired back to back form a complete link.

Top module: `link_startup_ctrl`

## Requirements
- R1: After reset the controller is in training: `tx_fill1` is 0 (fill 0 sent), `fdet_en` is 1 and `rfd` is 0, and the qualify count is empty.
- R2: In training, once `LOCK_CNT` consecutive error-free fill frames have been strobed, the outputs change on the edge that samples the last of them. Kind 2'b00 (fill 0) and kind 2'b01 (fill 1) both count. The new state is waiting, with `tx_fill1`=1, `fdet_en`=0 and `rfd`=0. Frequency mode is left only on such a frame.
- R3: In training, a strobed frame of kind 2'b10 (data) or 2'b11 (control), or any strobed frame with `rx_err`=1, empties the qualify count. A full run of `LOCK_CNT` clean fill frames is then needed again.
- R4: In waiting, a strobed error-free frame of kind 2'b01, 2'b10 or 2'b11 raises `rfd` on the next edge. `tx_fill1` stays 1 and `fdet_en` stays 0.
- R5: In waiting, a strobed error-free fill 0 frame (kind 2'b00) leaves the outputs unchanged.
- R6: A strobed frame with `rx_err`=1 returns the controller to training on the next edge, from any state.
- R7: In ready, a strobed error-free fill 0 frame returns the controller to training on the next edge, so `rfd` falls.
- R8: `rfd` rises only after a cycle in which fill 1 was already being sent. In a back-to-back pair, neither end has `rfd` high while its peer is still in frequency mode during bring-up.
- R9: In a cycle with `frame_vld`=0, `rx_kind` and `rx_err` have no effect: the outputs and the qualify count are held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_vld | input | 1 | One received frame is reported this cycle |
| rx_kind | input | 2 | Kind of received frame: 00 fill 0, 01 fill 1, 10 data, 11 control |
| rx_err | input | 1 | Received frame was flagged as a coding error (used only with frame_vld) |
| tx_fill1 | output | 1 | Fill frame to transmit: 0 selects fill 0, 1 selects fill 1 |
| fdet_en | output | 1 | Receiver in frequency-acquisition mode when 1, phase mode when 0 |
| rfd | output | 1 | Link ready for user data |

## Verification
The hardest situation to bring about is the recovery of a working link. An error at one end must pull the healthy peer out of ready through the fill 0 it sends. The two ends must then retrain without chasing each other's lock announcements. The bench reaches this by wiring two controllers through a registered link model. The model turns each end's outputs into frame kinds for the other end and can flag a single frame as errored. The bench then follows both `rfd` outputs through the drop and the second bring-up. A single-instance vector walk covers the exact qualify-count boundary and its restart cases. That walk places the seventh and eighth clean fill frames next to data frames, errored frames and idle cycles.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        KIND_FILL0 = 2'b00,
        KIND_FILL1 = 2'b01,
        KIND_DATA  = 2'b10,
        KIND_CTRL  = 2'b11
    } frame_kind_e;

    typedef enum logic [1:0] {
        ST_TRAIN = 2'b00,
        ST_WAIT  = 2'b01,
        ST_READY = 2'b10
    } link_state_e;

    typedef struct packed {
        link_state_e st;
    } ctrl_regs_t;

endpackage

// File: rtl/lsc_frame_class.sv
module lsc_frame_class
    import lsc_pkg::*;
(
    input  logic        frame_vld,
    input  logic [1:0]  rx_kind,
    input  logic        rx_err,
    output logic        bad_frame,
    output logic        clean_fill,
    output logic        clean_fill0,
    output logic        peer_up
);
    logic clean;

    always_comb begin
        clean       = frame_vld && !rx_err;
        bad_frame   = frame_vld && rx_err;
        // Both fill kinds have the upper kind bit clear.
        clean_fill  = clean && !rx_kind[1];
        clean_fill0 = clean && (rx_kind == KIND_FILL0);
        peer_up     = clean && (rx_kind != KIND_FILL0);
    end
endmodule

// File: rtl/lsc_qual_cnt.sv
module lsc_qual_cnt #(
    parameter int LOCK_CNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CW = (LOCK_CNT > 1) ? $clog2(LOCK_CNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOCK_CNT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        hit   = inc && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr || hit) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/lsc_state_out.sv
module lsc_state_out
    import lsc_pkg::*;
(
    input  link_state_e st,
    output logic        tx_fill1,
    output logic        fdet_en,
    output logic        rfd
);
    always_comb begin
        tx_fill1 = 1'b0;
        fdet_en  = 1'b1;
        rfd      = 1'b0;
        unique case (st)
            ST_TRAIN: begin
                tx_fill1 = 1'b0;
                fdet_en  = 1'b1;
                rfd      = 1'b0;
            end
            ST_WAIT: begin
                tx_fill1 = 1'b1;
                fdet_en  = 1'b0;
                rfd      = 1'b0;
            end
            ST_READY: begin
                tx_fill1 = 1'b1;
                fdet_en  = 1'b0;
                rfd      = 1'b1;
            end
            default: begin
                tx_fill1 = 1'b0;
                fdet_en  = 1'b1;
                rfd      = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/link_startup_ctrl.sv
module link_startup_ctrl
    import lsc_pkg::*;
#(
    parameter int LOCK_CNT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic [1:0] rx_kind,
    input  logic       rx_err,
    output logic       tx_fill1,
    output logic       fdet_en,
    output logic       rfd
);
    ctrl_regs_t r_d, r_q;

    logic bad_frame, clean_fill, clean_fill0, peer_up;
    logic cnt_clr, cnt_inc, cnt_hit;

    lsc_frame_class u_class (
        .frame_vld   (frame_vld),
        .rx_kind     (rx_kind),
        .rx_err      (rx_err),
        .bad_frame   (bad_frame),
        .clean_fill  (clean_fill),
        .clean_fill0 (clean_fill0),
        .peer_up     (peer_up)
    );

    lsc_qual_cnt #(.LOCK_CNT(LOCK_CNT)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .hit   (cnt_hit)
    );

    lsc_state_out u_out (
        .st       (r_q.st),
        .tx_fill1 (tx_fill1),
        .fdet_en  (fdet_en),
        .rfd      (rfd)
    );

    always_comb begin
        r_d     = r_q;
        cnt_inc = (r_q.st == ST_TRAIN) && clean_fill;
        // The run must be consecutive: any other strobed frame empties it,
        // and outside training the count is kept empty.
        cnt_clr = (r_q.st != ST_TRAIN) || (frame_vld && !clean_fill);

        unique case (r_q.st)
            ST_TRAIN: begin
                if (cnt_hit) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (bad_frame) begin
                    r_d.st = ST_TRAIN;
                end else if (peer_up) begin
                    r_d.st = ST_READY;
                end
            end
            ST_READY: begin
                if (bad_frame || clean_fill0) begin
                    r_d.st = ST_TRAIN;
                end
            end
            default: begin
                r_d.st = ST_TRAIN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st <= ST_TRAIN;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/link_startup_chk.sv
module link_startup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_vld,
    input logic [1:0] rx_kind,
    input logic       rx_err,
    input logic       tx_fill1,
    input logic       fdet_en,
    input logic       rfd
);
    // R2
    lock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fdet_en) |-> $past(frame_vld && !rx_err && !rx_kind[1]));

    // R4
    peer_up_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !rx_err && rx_kind != 2'b00 && tx_fill1 && !rfd) |=> rfd);

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !rx_err && rx_kind == 2'b00 && tx_fill1 && !rfd)
        |=> (tx_fill1 && !rfd && !fdet_en));

    // R6
    err_retrain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && rx_err) |=> (!rfd && fdet_en && !tx_fill1));

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_vld && !rx_err && rx_kind == 2'b00 && rfd) |=> (!rfd && fdet_en));

    // R8
    rfd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfd) |-> $past(tx_fill1 && !fdet_en));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> ($stable(rfd) && $stable(tx_fill1) && $stable(fdet_en)));
endmodule

bind link_startup_ctrl link_startup_chk u_chk (.*);

// File: tb/link_startup_ctrl_test.sv
`timescale 1ns/1ps
module link_startup_ctrl_test;
    localparam int QUAL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Single instance under vector test
    logic       u_vld = 1'b0;
    logic [1:0] u_kind = 2'b00;
    logic       u_err = 1'b0;
    logic       u_fill1, u_fdet, u_rfd;

    link_startup_ctrl #(.LOCK_CNT(QUAL)) uut (
        .clk(clk), .rst_n(rst_n), .frame_vld(u_vld), .rx_kind(u_kind),
        .rx_err(u_err), .tx_fill1(u_fill1), .fdet_en(u_fdet), .rfd(u_rfd)
    );

    // Back-to-back pair through a registered link model
    logic       pair_en = 1'b0;
    logic       inj_a = 1'b0;
    logic [1:0] a_kind, b_kind;
    logic       a_err;
    logic       a_fill1, a_fdet, a_rfd, b_fill1, b_fdet, b_rfd;

    link_startup_ctrl #(.LOCK_CNT(QUAL)) end_a (
        .clk(clk), .rst_n(rst_n), .frame_vld(pair_en), .rx_kind(a_kind),
        .rx_err(a_err), .tx_fill1(a_fill1), .fdet_en(a_fdet), .rfd(a_rfd)
    );
    link_startup_ctrl #(.LOCK_CNT(QUAL)) end_b (
        .clk(clk), .rst_n(rst_n), .frame_vld(pair_en), .rx_kind(b_kind),
        .rx_err(1'b0), .tx_fill1(b_fill1), .fdet_en(b_fdet), .rfd(b_rfd)
    );

    function automatic logic [1:0] line_kind(input logic f1, input logic rdy);
        if (rdy) return 2'b10;
        return f1 ? 2'b01 : 2'b00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            a_kind <= 2'b00;
            b_kind <= 2'b00;
            a_err  <= 1'b0;
        end else begin
            a_kind <= line_kind(b_fill1, b_rfd);
            b_kind <= line_kind(a_fill1, a_rfd);
            a_err  <= inj_a;
        end
    end

    // Outputs {tx_fill1, fdet_en, rfd}
    localparam logic [2:0] O_TRAIN = 3'b010;
    localparam logic [2:0] O_WAIT  = 3'b100;
    localparam logic [2:0] O_READY = 3'b101;

    // {req[14:11], rep[10:7], vld[6], kind[5:4], err[3], exp[2:0]}
    localparam int NV = 20;
    localparam logic [14:0] VEC [NV] = '{
        {4'd2, 4'd7, 1'b1, 2'd0, 1'b0, O_TRAIN},  // R2 run below limit
        {4'd9, 4'd1, 1'b0, 2'd0, 1'b1, O_TRAIN},  // R9 idle with err
        {4'd2, 4'd1, 1'b1, 2'd1, 1'b0, O_WAIT },  // R2 eighth clean fill
        {4'd5, 4'd1, 1'b1, 2'd0, 1'b0, O_WAIT },  // R5 peer fill 0
        {4'd9, 4'd1, 1'b0, 2'd1, 1'b0, O_WAIT },  // R9 idle
        {4'd4, 4'd1, 1'b1, 2'd1, 1'b0, O_READY},  // R4 peer fill 1
        {4'd4, 4'd1, 1'b1, 2'd2, 1'b0, O_READY},  // R4 data keeps ready
        {4'd9, 4'd1, 1'b0, 2'd0, 1'b1, O_READY},  // R9 idle with err
        {4'd7, 4'd1, 1'b1, 2'd0, 1'b0, O_TRAIN},  // R7 fill 0 in ready
        {4'd3, 4'd7, 1'b1, 2'd0, 1'b0, O_TRAIN},  // R3 partial run
        {4'd3, 4'd1, 1'b1, 2'd2, 1'b0, O_TRAIN},  // R3 data restarts
        {4'd3, 4'd7, 1'b1, 2'd0, 1'b0, O_TRAIN},  // R3 partial run
        {4'd3, 4'd1, 1'b1, 2'd0, 1'b1, O_TRAIN},  // R3 errored fill restarts
        {4'd3, 4'd7, 1'b1, 2'd1, 1'b0, O_TRAIN},  // R3 partial run
        {4'd2, 4'd1, 1'b1, 2'd0, 1'b0, O_WAIT },  // R2 limit reached
        {4'd4, 4'd1, 1'b1, 2'd3, 1'b0, O_READY},  // R4 control frame
        {4'd6, 4'd1, 1'b1, 2'd2, 1'b1, O_TRAIN},  // R6 error in ready
        {4'd2, 4'd7, 1'b1, 2'd0, 1'b0, O_TRAIN},  // R2 partial run
        {4'd2, 4'd1, 1'b1, 2'd0, 1'b0, O_WAIT },  // R2 limit reached
        {4'd6, 4'd1, 1'b1, 2'd1, 1'b1, O_TRAIN}   // R6 error in waiting
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input logic v, input logic [1:0] k, input logic e);
        u_vld  = v;
        u_kind = k;
        u_err  = e;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [2:0] got;
        int viol;
        bit a_drop, b_drop, both_up;

        repeat (3) @(negedge clk);
        // R1: reset state
        check({u_fill1, u_fdet, u_rfd} == O_TRAIN, "R1", {u_fill1, u_fdet, u_rfd}, O_TRAIN);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            for (int r = 0; r < int'(VEC[i][10:7]); r++) begin
                apply(VEC[i][6], VEC[i][5:4], VEC[i][3]);
                got = {u_fill1, u_fdet, u_rfd};
                if (got != VEC[i][2:0]) begin
                    errors++;
                    $display("FAIL R%0d row %0d rep %0d actual=%b expected=%b",
                             VEC[i][14:11], i, r, got, VEC[i][2:0]);
                end
                checks++;
            end
        end

        // R1: reset from ready clears state and the qualify count
        for (int r = 0; r < QUAL; r++) apply(1'b1, 2'd0, 1'b0);
        apply(1'b1, 2'd1, 1'b0);
        check({u_fill1, u_fdet, u_rfd} == O_READY, "R4 pre-reset", {u_fill1, u_fdet, u_rfd}, O_READY);
        for (int r = 0; r < QUAL - 1; r++) apply(1'b0, 2'd0, 1'b0);
        rst_n = 1'b0;
        apply(1'b1, 2'd0, 1'b0);
        check({u_fill1, u_fdet, u_rfd} == O_TRAIN, "R1 reset", {u_fill1, u_fdet, u_rfd}, O_TRAIN);
        rst_n = 1'b1;
        for (int r = 0; r < QUAL - 1; r++) apply(1'b1, 2'd0, 1'b0);
        check({u_fill1, u_fdet, u_rfd} == O_TRAIN, "R1 count cleared", {u_fill1, u_fdet, u_rfd}, O_TRAIN);
        apply(1'b1, 2'd0, 1'b0);
        check({u_fill1, u_fdet, u_rfd} == O_WAIT, "R2 after reset", {u_fill1, u_fdet, u_rfd}, O_WAIT);
        apply(1'b0, 2'd0, 1'b0);

        // Duplex pair bring-up: R4, R8
        pair_en = 1'b1;
        viol = 0;
        both_up = 1'b0;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if ((a_rfd && b_fdet) || (b_rfd && a_fdet)) viol++;
            if (a_rfd && b_rfd) both_up = 1'b1;
        end
        check(both_up, "R4 pair ready", both_up, 1);
        check(viol == 0, "R8 no data to untrained peer", viol, 0);

        // Inject one errored frame at end A: R6, R7
        inj_a = 1'b1;
        @(negedge clk);
        inj_a = 1'b0;
        a_drop = 1'b0;
        b_drop = 1'b0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (!a_rfd) a_drop = 1'b1;
            if (!b_rfd) b_drop = 1'b1;
        end
        check(a_drop, "R6 erroring end retrains", a_drop, 1);
        check(b_drop, "R7 peer pulled into training", b_drop, 1);

        both_up = 1'b0;
        for (int c = 0; c < 80; c++) begin
            @(negedge clk);
            if (a_rfd && b_rfd) both_up = 1'b1;
        end
        check(both_up, "R4 pair recovers", both_up, 1);
        check(!a_fdet && !b_fdet, "R8 both in phase mode", {a_fdet, b_fdet}, 0);

        finish_run();
    end
endmodule